// File: doc/BRIEF.md
# ADC Synchronization Pulse Generator

This block drives a single SYNC line that fans out to a group of delta-sigma converters that all run from one master conversion clock. The pulse is produced by counting periods of that same clock, so it never drifts against the conversion clock. A programmable divide ratio N sets the spacing and a programmable width W sets the high time. For example, a 1.024 MHz clock with N = 1024 gives a 1 kHz sync rate.

Two modes are available. In continuous mode a pulse starts every N clocks for as long as enable is held. In single-shot mode exactly one pulse is issued after enable, which aligns all converters once at start-up. The SYNC line is launched from a flop clocked on the falling clock edge, so its edges sit about half a period away from any rising edge.

New settings take effect only at a period boundary. An illegal pair of settings is refused: the last good pair stays in use and an error flag is raised. While the block is disabled, an asynchronous external request is reclocked on the falling edge and produces one pulse. A one-clock strobe marks the start of every pulse.

Top module: `sync_pulse_gen`

## Requirements
- R1: In continuous mode, with k counting the rising edges at which enable is sampled high (k = 0 being the first), SYNC is high in the half period after the falling edge that follows edge k exactly when (k mod N) < W. The first pulse therefore starts on the first clock after enable.
- R2: Each pulse stays high for exactly W clock periods, and successive rising edges of SYNC are exactly N clocks apart.
- R3: A width below 2 is never accepted. Such a setting keeps the previous values in use and raises the error flag.
- R4: SYNC changes only on falling clock edges. Sampled between a rising edge and the next falling edge, it still shows the value from the previous period.
- R5: In single-shot mode (oneShot = 1), only the first period after enable contains a pulse. SYNC then stays low until enable is removed.
- R6: A change of N or W that arrives while enabled is applied only at the end of the current period. The counter neither restarts nor slips.
- R7: A pair with W >= N is refused and the previous pair stays in use. The flag cfgError is high in the cycle after any rising edge at which the inputs hold a refused pair, and low otherwise.
- R8: During reset, SYNC, the strobe and cfgError are all low. The counter is cleared and the reset-default settings are loaded.
- R9: syncStrobe is high for exactly one clock, beginning at the rising edge that follows the start of a pulse. Each pulse gives one strobe.
- R10: While disabled, a rising edge on extReq passes through two falling-edge flops and then starts one pulse of W clocks. When extReq goes high just after a falling edge, SYNC is first seen high in the third following clock period.
- R11: While enabled, extReq has no effect on SYNC.
- R12: Dropping enable in the middle of a pulse does not cut the pulse short. It still lasts W clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master conversion clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the period counter while high |
| oneShot | input | 1 | 1 selects single-shot mode, 0 selects continuous mode |
| divRatio | input | CNT_W | Period N, in clocks |
| pulseWidth | input | CNT_W | High time W, in clocks |
| extReq | input | 1 | Asynchronous external pulse request |
| syncOut | output | 1 | SYNC line to the converters, launched on the falling edge |
| syncStrobe | output | 1 | One-clock marker at the start of each pulse |
| cfgError | output | 1 | High while the presented N/W pair is refused |

## Verification
The bench sweeps every legal width for small periods and compares SYNC cycle by cycle against the formula (k mod N) < W. A design that restarted the count, launched on the wrong edge, or stretched the pulse by one clock would therefore miss in the first or last cycle of a pulse. Settings are rewritten in the middle of a period, both legal pairs and the two kinds of illegal pair. This exposes a block that applies a change at once, which shortens a period and makes every converter resynchronize, and a block that accepts W >= N or W < 2. The bench also drops enable while a pulse is high, which would give a runt pulse below the minimum width if handled wrongly. It measures the latency and width of an external request while disabled, and toggles that request while enabled, where any effect would be a spurious pulse.

// File: rtl/sync_pulse_pkg.sv
package sync_pulse_pkg;
  localparam int MIN_WIDTH = 2;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic loadCfg;
    logic pulseReq;
  } ctlStrobe_t;
endpackage

// File: rtl/sync_pulse_datapath.sv
module sync_pulse_datapath
  import sync_pulse_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_RESET   = 1024,
  parameter int WIDTH_RESET = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [CNT_W-1:0] divRatio,
  input  logic [CNT_W-1:0] pulseWidth,
  output logic             atWrap,
  output logic             atWidthEnd,
  output logic             inPulse,
  output logic             syncOut,
  output logic             syncStrobe,
  output logic             cfgError
);
  localparam logic [CNT_W-1:0] MinW = CNT_W'(MIN_WIDTH);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] actDiv;
  logic [CNT_W-1:0] actW;
  logic             reqDly;
  logic             cfgOk;

  assign cfgOk      = (pulseWidth >= MinW) && (pulseWidth < divRatio);
  assign atWrap     = (cnt == actDiv - 1'b1);
  assign atWidthEnd = (cnt == actW - 1'b1);
  assign inPulse    = (cnt < actW);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      actDiv     <= CNT_W'(DIV_RESET);
      actW       <= CNT_W'(WIDTH_RESET);
      cfgError   <= 1'b0;
      reqDly     <= 1'b0;
      syncStrobe <= 1'b0;
    end else begin
      if (ctl.clrCnt)      cnt <= '0;
      else if (ctl.incCnt) cnt <= atWrap ? '0 : cnt + 1'b1;
      if (ctl.loadCfg && cfgOk) begin
        actDiv <= divRatio;
        actW   <= pulseWidth;
      end
      cfgError   <= !cfgOk;
      reqDly     <= ctl.pulseReq;
      syncStrobe <= ctl.pulseReq && !reqDly;
    end
  end

  // Launch on the falling edge: half a period clear of rising edges.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) syncOut <= 1'b0;
    else       syncOut <= ctl.pulseReq;
  end
endmodule

// File: rtl/sync_pulse_ctrl.sv
module sync_pulse_ctrl
  import sync_pulse_pkg::*;
#(
  parameter int EXT_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       oneShot,
  input  logic       extReq,
  input  logic       atWrap,
  input  logic       atWidthEnd,
  input  logic       inPulse,
  output ctlStrobe_t ctl
);
  logic [EXT_STAGES-1:0] extPipe;
  logic extSync, extPrev, extRise;
  logic active, shotDone, holdBusy, activeReq;

  generate
    for (genvar i = 0; i < EXT_STAGES; i++) begin : g_extSync
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) extPipe[i] <= 1'b0;
        else       extPipe[i] <= (i == 0) ? extReq : extPipe[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign extSync   = extPipe[EXT_STAGES-1];
  assign extRise   = extSync && !extPrev;
  assign activeReq = active && inPulse && !(oneShot && shotDone);

  always_comb begin
    ctl = '0;
    if (enable) begin
      ctl.clrCnt  = !active;
      ctl.incCnt  = active;
      ctl.loadCfg = !active || atWrap;
    end else if (active) begin
      if (activeReq && !atWidthEnd) ctl.incCnt = 1'b1;
      else begin
        ctl.clrCnt  = 1'b1;
        ctl.loadCfg = 1'b1;
      end
    end else if (holdBusy) begin
      ctl.incCnt = 1'b1;
    end else begin
      ctl.clrCnt  = 1'b1;
      ctl.loadCfg = 1'b1;
    end
    ctl.pulseReq = activeReq || holdBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev  <= 1'b0;
      active   <= 1'b0;
      shotDone <= 1'b0;
      holdBusy <= 1'b0;
    end else begin
      extPrev <= extSync;
      if (enable) begin
        active   <= 1'b1;
        holdBusy <= 1'b0;
        if (active && atWrap && oneShot) shotDone <= 1'b1;
      end else begin
        active   <= 1'b0;
        shotDone <= 1'b0;
        if (active)        holdBusy <= activeReq && !atWidthEnd;
        else if (holdBusy) holdBusy <= !atWidthEnd;
        else               holdBusy <= extRise;
      end
    end
  end
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import sync_pulse_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_RESET   = 1024,
  parameter int WIDTH_RESET = 2,
  parameter int EXT_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             oneShot,
  input  logic [CNT_W-1:0] divRatio,
  input  logic [CNT_W-1:0] pulseWidth,
  input  logic             extReq,
  output logic             syncOut,
  output logic             syncStrobe,
  output logic             cfgError
);
  ctlStrobe_t ctl;
  logic atWrap, atWidthEnd, inPulse;

  sync_pulse_ctrl #(.EXT_STAGES(EXT_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .oneShot(oneShot), .extReq(extReq),
    .atWrap(atWrap), .atWidthEnd(atWidthEnd), .inPulse(inPulse), .ctl(ctl)
  );

  sync_pulse_datapath #(.CNT_W(CNT_W), .DIV_RESET(DIV_RESET), .WIDTH_RESET(WIDTH_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .divRatio(divRatio), .pulseWidth(pulseWidth),
    .atWrap(atWrap), .atWidthEnd(atWidthEnd), .inPulse(inPulse),
    .syncOut(syncOut), .syncStrobe(syncStrobe), .cfgError(cfgError)
  );
endmodule

// File: rtl/sync_pulse_checker.sv
module sync_pulse_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic oneShot,
  input logic syncOut,
  input logic syncStrobe
);
  logic [1:0] shotStrobes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   shotStrobes <= '0;
    else if (!enable || !oneShot) shotStrobes <= '0;
    else if (syncStrobe && shotStrobes != 2'd3) shotStrobes <= shotStrobes + 1'b1;
  end

  AST_HIGH_MIN: assert property (@(negedge clk) disable iff (!rstN)
    $fell(syncOut) |-> $past(syncOut, 2)); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    syncStrobe |=> !syncStrobe); // R9

  AST_STROBE_IN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    syncStrobe |-> syncOut); // R9

  AST_ONE_SHOT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && oneShot && shotStrobes != 2'd0) |-> !syncStrobe); // R5
endmodule

bind sync_pulse_gen sync_pulse_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .oneShot(oneShot),
  .syncOut(syncOut), .syncStrobe(syncStrobe)
);

// File: tb/tb_sync_pulse_gen.sv
module tb_sync_pulse_gen;
  localparam int CW = 16;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, oneShot = 1'b0, extReq = 1'b0;
  logic [CW-1:0] divRatio = 16'd1024, pulseWidth = 16'd2;
  logic syncOut, syncStrobe, cfgError;

  int checks = 0, fails = 0;
  bit done = 0;

  bit mActive, mShot, req0, req1, req2;
  int mCnt, mDiv, mW;

  sync_pulse_gen #(.CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .oneShot(oneShot),
    .divRatio(divRatio), .pulseWidth(pulseWidth), .extReq(extReq),
    .syncOut(syncOut), .syncStrobe(syncStrobe), .cfgError(cfgError)
  );

  always #5 clk = ~clk;

  function automatic bit cfgValid(int n, int w);
    return (w >= 2) && (w < n);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic modelStart();
    mActive = 0; mShot = 0; mCnt = 0; req0 = 0; req1 = 0; req2 = 0;
    mDiv = int'(divRatio); mW = int'(pulseWidth);
  endtask

  // One enabled clock with cycle-accurate comparison against the model.
  task automatic step(string tag);
    bit wrap, ld, expErr;
    @(posedge clk);
    req2 = req1; req1 = req0;
    wrap = mActive && (mCnt == mDiv - 1);
    ld = !mActive || wrap;
    if (mActive && wrap && oneShot) mShot = 1;
    mCnt = (!mActive || wrap) ? 0 : mCnt + 1;
    mActive = 1;
    if (ld && cfgValid(int'(divRatio), int'(pulseWidth))) begin
      mDiv = int'(divRatio); mW = int'(pulseWidth);
    end
    req0 = (mCnt < mW) && !(oneShot && mShot);
    expErr = !cfgValid(int'(divRatio), int'(pulseWidth));
    #2;
    check(syncOut == req1, {"R4 ", tag}, int'(syncOut), int'(req1));
    #5;
    check(syncOut == req0, tag, int'(syncOut), int'(req0));
    check(syncStrobe == (req1 && !req2), "R9", int'(syncStrobe), int'(req1 && !req2));
    check(cfgError == expErr, "R7", int'(cfgError), int'(expErr));
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #7;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int highs, strobes, firstHigh;
    #12;
    check(syncOut == 0, "R8", int'(syncOut), 0);
    check(syncStrobe == 0, "R8", int'(syncStrobe), 0);
    check(cfgError == 0, "R8", int'(cfgError), 0);
    #10 rstN = 1'b1;
    idle(3);
    check(syncOut == 0 && cfgError == 0, "R8", int'(syncOut), 0);

    // Continuous-mode sweep over all legal widths (R1 R2).
    for (int n = 3; n <= 9; n++) begin
      for (int w = 2; w < n; w++) begin
        divRatio = CW'(n); pulseWidth = CW'(w);
        idle(2);
        modelStart();
        enable = 1'b1;
        for (int k = 0; k < 3 * n + 2; k++) step("R1 R2");
        enable = 1'b0;
        idle(12);
      end
    end

    // Single-shot (R5).
    oneShot = 1'b1;
    for (int n = 3; n <= 6; n++) begin
      divRatio = CW'(n); pulseWidth = 16'd2;
      idle(2);
      modelStart();
      enable = 1'b1;
      for (int k = 0; k < 4 * n; k++) step("R5");
      enable = 1'b0;
      idle(8);
    end
    oneShot = 1'b0;

    // External request ignored while running (R11).
    divRatio = 16'd5; pulseWidth = 16'd2;
    idle(2);
    modelStart();
    enable = 1'b1;
    for (int k = 0; k < 30; k++) begin
      if (k % 3 == 0) extReq = ~extReq;
      step("R11");
    end
    extReq = 1'b0;
    for (int k = 0; k < 4; k++) step("R11");
    enable = 1'b0;
    idle(10);

    // Reconfiguration mid-period, legal and illegal (R6 R7 R3).
    divRatio = 16'd6; pulseWidth = 16'd2;
    idle(2);
    modelStart();
    enable = 1'b1;
    for (int k = 0; k < 8; k++) step("R6");
    divRatio = 16'd4; pulseWidth = 16'd3;
    for (int k = 0; k < 16; k++) step("R6");
    divRatio = 16'd4; pulseWidth = 16'd4;
    for (int k = 0; k < 10; k++) step("R7");
    divRatio = 16'd9; pulseWidth = 16'd1;
    for (int k = 0; k < 10; k++) step("R3");
    divRatio = 16'd5; pulseWidth = 16'd2;
    for (int k = 0; k < 12; k++) step("R6");
    enable = 1'b0;
    idle(10);

    // Disable in the middle of a pulse (R12).
    divRatio = 16'd8; pulseWidth = 16'd4;
    idle(2);
    modelStart();
    enable = 1'b1;
    step("R12"); step("R12");
    enable = 1'b0;
    highs = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #7;
      if (syncOut) highs++;
    end
    check(highs == 2, "R12", highs, 2);
    idle(4);

    // External request while disabled (R10).
    for (int w = 3; w >= 2; w--) begin
      divRatio = 16'd7; pulseWidth = CW'(w);
      idle(3);
      extReq = 1'b1;
      highs = 0; strobes = 0; firstHigh = -1;
      for (int k = 0; k < 14; k++) begin
        @(posedge clk); #7;
        if (syncOut) begin
          highs++;
          if (firstHigh < 0) firstHigh = k;
        end
        if (syncStrobe) strobes++;
      end
      check(highs == w, "R10", highs, w);
      check(strobes == 1, "R10", strobes, 1);
      check(firstHigh == 2, "R10", firstHigh, 2);
      extReq = 1'b0;
      idle(6);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule